// File: doc/BRIEF.md
# Address Region Attribute Decoder

This block keeps a set of programmable physical-address windows, each with its own attribute byte, and classifies every incoming 32-bit physical address against them. Software reaches the configuration through a byte-wide indexed port pair. A write to the index port selects a register. The next access to the data port reads or writes that register. Each window has a 20-bit start (address bits 31..12), a 4-bit logarithmic size code and a control byte. A single global enable bit gates all matching.

A cache or bus controller drives `lookup_addr` every cycle. One cycle later `attr_o` holds the attributes for that address: cacheable, weak write ordering, weak locking, write gathering, write-through and local-bus suppression. When several windows overlap, the lowest-numbered one decides. When no window matches, the address is plain cacheable memory.

The access port is a two-state machine. In state `PORT_IDLE` no index is held. In state `PORT_ARMED` an index is held. The transitions are:
- **arm**: an index write in `PORT_IDLE` moves to `PORT_ARMED`.
- **re-index**: an index write in `PORT_ARMED` replaces the index and stays in `PORT_ARMED`.
- **consume**: any data access in `PORT_ARMED` returns to `PORT_IDLE`.
- **stale**: a data access in `PORT_IDLE` stays in `PORT_IDLE` and has no effect.

Top module: `addr_region_decoder`

## Requirements
- R1: After reset, every implemented register reads 0x00, no index is held, and `attr_o` equals 0x01 (cacheable only).
- R2: A write with `io_addr`=0x22 stores `io_wdata` as the register index. The next access with `io_addr`=0x23 writes `io_wdata` to that register, or returns its value combinationally on `io_rdata` while the read is presented.
- R3: Every data-port access consumes the index. A later data access made without a fresh index write is ignored: a write changes nothing, and a read returns 0xFF.
- R4: Window i (0..7) occupies indexes 0xC4+3i through 0xC6+3i. These bytes hold, in order, start[31:24], start[23:16], and {start[15:12], size code in bits 3:0}. Each byte reads back as written.
- R5: The control byte of window i is at index 0xDC+i and reads back as written. Index 0xE9 stores only bit 5, which is the global enable; its other bits read as 0.
- R6: Every index outside 0xC4..0xE3 and 0xE9 reads as 0x00, and writes to it change no register.
- R7: Size code 0 disables a window. Code s in 1..14 covers 2^(11+s) bytes. Code 15 covers all addresses. Only the address bits above the window size are compared, so start bits below the size are ignored.
- R8: While the global enable bit is 0, `attr_o` is 0x01 for every address.
- R9: `attr_o` bits are [0] cacheable, [1] weak write ordering, [2] weak locking, [3] write gathering, [4] write-through, [5] local-bus suppression. Bits 5:1 copy control bits 5:1 of the winning window. Bit 0 is the inverse of control bit 0 for windows 0..6, and equal to control bit 0 for window 7.
- R10: When several enabled windows match an address, the lowest-numbered one supplies the attributes.
- R11: When no enabled window matches, `attr_o` is 0x01.
- R12: `attr_o` is registered. It shows the result for the `lookup_addr` presented in the previous cycle, computed from the register contents before that clock edge. A register write at the same edge becomes visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | Port access strobe, one access per cycle |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 8 | Port address: 0x22 index, 0x23 data; other values are ignored |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the current data-port read |
| lookup_addr | input | 32 | Physical address to classify |
| attr_o | output | 6 | Registered attributes of the previous cycle's address |

## Verification
A configuration write and an address lookup can fall in the same cycle. The bench provokes this by presenting a data-port write that flips a window's control byte in the same cycle as a lookup of an address inside that window. It judges the result by requiring the old attributes one cycle later and the new ones the cycle after that. Random traffic also mixes reconfiguration with back-to-back lookups; each lookup is checked against a bench model that is only updated after the write has landed.

// File: rtl/arad_pkg.sv
package arad_pkg;

    typedef enum logic [0:0] {
        PORT_IDLE  = 1'b0,
        PORT_ARMED = 1'b1
    } port_state_e;

    // attribute vector, LSB first: cacheable .. local-bus suppression
    typedef struct packed {
        logic lb_off;
        logic wthru;
        logic wgather;
        logic wlock;
        logic wwo;
        logic cacheable;
    } attr_t;

    localparam attr_t ATTR_DEFAULT = attr_t'(6'b000001);
    localparam int    PAGE_BITS    = 12;
    localparam int    START_W      = 32 - PAGE_BITS;

    // address bits that take part in the compare for a given size code
    function automatic logic [31:0] size_mask(input logic [3:0] code);
        logic [31:0] m;
        if (code == 4'd15) begin
            m = 32'd0;
        end else begin
            m = ~((32'd1 << (5'd11 + 5'(code))) - 32'd1);
        end
        return m;
    endfunction

endpackage

// File: rtl/arad_port_fsm.sv
module arad_port_fsm
    import arad_pkg::*;
#(
    parameter logic [7:0] INDEX_PORT = 8'h22,
    parameter logic [7:0] DATA_PORT  = 8'h23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_en,
    input  logic       io_we,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    input  logic [7:0] reg_rdata,
    output logic [7:0] io_rdata,
    output logic [7:0] reg_idx,
    output logic [7:0] reg_wdata,
    output logic       reg_wr,
    output logic       armed
);

    port_state_e state_q, state_d;
    logic [7:0]  idx_q, idx_d;
    logic        idx_acc, data_acc;

    assign idx_acc  = io_en && (io_addr == INDEX_PORT);
    assign data_acc = io_en && (io_addr == DATA_PORT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
            idx_q   <= 8'h00;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            PORT_IDLE: begin
                if (idx_acc && io_we) begin
                    state_d = PORT_ARMED;
                    idx_d   = io_wdata;
                end
            end
            PORT_ARMED: begin
                if (idx_acc && io_we) begin
                    idx_d = io_wdata;
                end else if (data_acc) begin
                    state_d = PORT_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        reg_wr    = 1'b0;
        io_rdata  = 8'h00;
        reg_idx   = idx_q;
        reg_wdata = io_wdata;
        unique case (state_q)
            PORT_IDLE: begin
                if (data_acc && !io_we) io_rdata = 8'hFF;
            end
            PORT_ARMED: begin
                if (data_acc) begin
                    if (io_we) reg_wr = 1'b1;
                    else       io_rdata = reg_rdata;
                end
            end
        endcase
    end

    assign armed = (state_q == PORT_ARMED);

    assert_index_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_acc && io_we) |=> armed);

    assert_data_consumes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !(idx_acc && io_we)) |=> !armed);

    assert_stale_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !reg_wr);

endmodule

// File: rtl/arad_regfile.sv
module arad_regfile
    import arad_pkg::*;
#(
    parameter int         N_RGN       = 8,
    parameter int         RGN_BASE    = 8'hC4,
    parameter int         CTRL_BASE   = 8'hDC,
    parameter logic [7:0] GLOBAL_IDX  = 8'hE9,
    parameter int         GLOBAL_BIT  = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [7:0]                      reg_idx,
    input  logic [7:0]                      reg_wdata,
    output logic [7:0]                      reg_rdata,
    output logic [N_RGN-1:0][START_W-1:0]   rgn_start,
    output logic [N_RGN-1:0][3:0]           rgn_size,
    output logic [N_RGN-1:0][7:0]           rgn_ctrl,
    output logic                            glob_en
);

    localparam int N_BYTES = 3 * N_RGN;

    logic [N_BYTES-1:0][7:0] rbyte_q;
    logic [N_RGN-1:0][7:0]   ctrl_q;
    logic                    glob_q;
    logic                    idx_known;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbyte_q <= '0;
            ctrl_q  <= '0;
            glob_q  <= 1'b0;
        end else if (reg_wr) begin
            for (int k = 0; k < N_BYTES; k++) begin
                if (reg_idx == 8'(RGN_BASE + k)) rbyte_q[k] <= reg_wdata;
            end
            for (int k = 0; k < N_RGN; k++) begin
                if (reg_idx == 8'(CTRL_BASE + k)) ctrl_q[k] <= reg_wdata;
            end
            if (reg_idx == GLOBAL_IDX) glob_q <= reg_wdata[GLOBAL_BIT];
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        idx_known = 1'b0;
        for (int k = 0; k < N_BYTES; k++) begin
            if (reg_idx == 8'(RGN_BASE + k)) begin
                reg_rdata = rbyte_q[k];
                idx_known = 1'b1;
            end
        end
        for (int k = 0; k < N_RGN; k++) begin
            if (reg_idx == 8'(CTRL_BASE + k)) begin
                reg_rdata = ctrl_q[k];
                idx_known = 1'b1;
            end
        end
        if (reg_idx == GLOBAL_IDX) begin
            reg_rdata[GLOBAL_BIT] = glob_q;
            idx_known = 1'b1;
        end
    end

    for (genvar g = 0; g < N_RGN; g++) begin : g_fields
        assign rgn_start[g] = {rbyte_q[3*g], rbyte_q[3*g+1], rbyte_q[3*g+2][7:4]};
        assign rgn_size[g]  = rbyte_q[3*g+2][3:0];
        assign rgn_ctrl[g]  = ctrl_q[g];
    end
    assign glob_en = glob_q;

    assert_unknown_idx_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr || !idx_known) |=> ($stable(rbyte_q) && $stable(ctrl_q) && $stable(glob_q)));

endmodule

// File: rtl/arad_match.sv
module arad_match
    import arad_pkg::*;
#(
    parameter int N_RGN = 8
) (
    input  logic [31:0]                    lookup_addr,
    input  logic [N_RGN-1:0][START_W-1:0]  rgn_start,
    input  logic [N_RGN-1:0][3:0]          rgn_size,
    input  logic [N_RGN-1:0][7:0]          rgn_ctrl,
    input  logic                           glob_en,
    output logic [N_RGN-1:0]               win_vec,
    output attr_t                          attr
);

    logic [N_RGN-1:0] hit_vec;

    for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
        logic [31:0] mask;
        logic [31:0] base;
        assign mask       = size_mask(rgn_size[g]);
        assign base       = {rgn_start[g], {PAGE_BITS{1'b0}}};
        assign hit_vec[g] = glob_en && (rgn_size[g] != 4'd0)
                            && (((lookup_addr ^ base) & mask) == 32'd0);
    end

    always_comb begin
        logic       found;
        logic [7:0] wctrl;
        logic       wlast;
        found   = 1'b0;
        wctrl   = 8'h00;
        wlast   = 1'b0;
        win_vec = '0;
        for (int k = 0; k < N_RGN; k++) begin
            if (hit_vec[k] && !found) begin
                found      = 1'b1;
                win_vec[k] = 1'b1;
                wctrl      = rgn_ctrl[k];
                wlast      = (k == N_RGN - 1);
            end
        end
        if (found) begin
            attr.lb_off    = wctrl[5];
            attr.wthru     = wctrl[4];
            attr.wgather   = wctrl[3];
            attr.wlock     = wctrl[2];
            attr.wwo       = wctrl[1];
            attr.cacheable = wlast ? wctrl[0] : ~wctrl[0];
        end else begin
            attr = ATTR_DEFAULT;
        end
    end

endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
    import arad_pkg::*;
#(
    parameter int         N_RGN      = 8,
    parameter logic [7:0] INDEX_PORT = 8'h22,
    parameter logic [7:0] DATA_PORT  = 8'h23,
    parameter int         RGN_BASE   = 8'hC4,
    parameter int         CTRL_BASE  = 8'hDC,
    parameter logic [7:0] GLOBAL_IDX = 8'hE9,
    parameter int         GLOBAL_BIT = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_en,
    input  logic        io_we,
    input  logic [7:0]  io_addr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic [31:0] lookup_addr,
    output logic [5:0]  attr_o
);

    logic [7:0]                     reg_idx, reg_wdata, reg_rdata;
    logic                           reg_wr, armed, glob_en;
    logic [N_RGN-1:0][START_W-1:0]  rgn_start;
    logic [N_RGN-1:0][3:0]          rgn_size;
    logic [N_RGN-1:0][7:0]          rgn_ctrl;
    logic [N_RGN-1:0]               win_vec;
    attr_t                          attr_d, attr_q;

    arad_port_fsm #(.INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)) u_port (
        .clk(clk), .rst_n(rst_n), .io_en(io_en), .io_we(io_we),
        .io_addr(io_addr), .io_wdata(io_wdata), .reg_rdata(reg_rdata),
        .io_rdata(io_rdata), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .armed(armed)
    );

    arad_regfile #(
        .N_RGN(N_RGN), .RGN_BASE(RGN_BASE), .CTRL_BASE(CTRL_BASE),
        .GLOBAL_IDX(GLOBAL_IDX), .GLOBAL_BIT(GLOBAL_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rgn_start(rgn_start),
        .rgn_size(rgn_size), .rgn_ctrl(rgn_ctrl), .glob_en(glob_en)
    );

    arad_match #(.N_RGN(N_RGN)) u_match (
        .lookup_addr(lookup_addr), .rgn_start(rgn_start), .rgn_size(rgn_size),
        .rgn_ctrl(rgn_ctrl), .glob_en(glob_en), .win_vec(win_vec), .attr(attr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) attr_q <= ATTR_DEFAULT;
        else        attr_q <= attr_d;
    end

    assign attr_o = attr_q;

    assert_global_off_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (attr_o == 6'h01));

    assert_single_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_vec));

    assert_no_window_default_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vec == '0) |=> (attr_o == 6'h01));

endmodule

// File: tb/addr_region_decoder_bench.sv
module addr_region_decoder_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_en = 1'b0, io_we = 1'b0;
    logic [7:0]  io_addr = 8'h00, io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [31:0] lookup_addr = 32'h0;
    logic [5:0]  attr_o;

    int errors = 0;
    int checks = 0;

    bit [7:0] m_rb [24];
    bit [7:0] m_ctrl [8];
    bit       m_glob;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_region_decoder u_addr_region_decoder (
        .clk(clk), .rst_n(rst_n), .io_en(io_en), .io_we(io_we),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .lookup_addr(lookup_addr), .attr_o(attr_o)
    );

    function automatic bit [7:0] exp_read(input bit [7:0] idx);
        if (idx >= 8'hC4 && idx <= 8'hDB) return m_rb[idx - 8'hC4];
        if (idx >= 8'hDC && idx <= 8'hE3) return m_ctrl[idx - 8'hDC];
        if (idx == 8'hE9) return {2'b00, m_glob, 5'b00000};
        return 8'h00;
    endfunction

    function automatic void model_write(input bit [7:0] idx, input bit [7:0] d);
        if (idx >= 8'hC4 && idx <= 8'hDB) m_rb[idx - 8'hC4] = d;
        else if (idx >= 8'hDC && idx <= 8'hE3) m_ctrl[idx - 8'hDC] = d;
        else if (idx == 8'hE9) m_glob = d[5];
    endfunction

    function automatic bit [5:0] exp_attr(input bit [31:0] a);
        for (int i = 0; i < 8; i++) begin
            bit [3:0]  sz = m_rb[3*i+2][3:0];
            bit [31:0] st = {m_rb[3*i], m_rb[3*i+1], m_rb[3*i+2][7:4], 12'h000};
            bit        hit;
            hit = 1'b0;
            if (m_glob && sz != 0) begin
                if (sz == 15) hit = 1'b1;
                else hit = ((a >> (11 + sz)) == (st >> (11 + sz)));
            end
            if (hit) return {m_ctrl[i][5:1], (i == 7) ? m_ctrl[i][0] : ~m_ctrl[i][0]};
        end
        return 6'h01;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus(input bit [7:0] a, input bit we, input bit [7:0] d, output bit [7:0] rd);
        @(negedge clk);
        io_en = 1'b1; io_we = we; io_addr = a; io_wdata = d;
        #1 rd = io_rdata;
        @(posedge clk);
        #1 io_en = 1'b0; io_we = 1'b0;
    endtask

    task automatic cfg_write(input bit [7:0] idx, input bit [7:0] d);
        bit [7:0] rd;
        bus(8'h22, 1'b1, idx, rd);
        bus(8'h23, 1'b1, d, rd);
        model_write(idx, d);
    endtask

    task automatic cfg_read_check(input string req, input bit [7:0] idx);
        bit [7:0] rd;
        bus(8'h22, 1'b1, idx, rd);
        bus(8'h23, 1'b0, 8'h00, rd);
        check(req, rd, exp_read(idx));
    endtask

    task automatic set_window(input int i, input bit [31:0] st, input bit [3:0] sz, input bit [7:0] c);
        cfg_write(8'(8'hC4 + 3*i), st[31:24]);
        cfg_write(8'(8'hC5 + 3*i), st[23:16]);
        cfg_write(8'(8'hC6 + 3*i), {st[15:12], sz});
        cfg_write(8'(8'hDC + i), c);
    endtask

    task automatic look(input string req, input bit [31:0] a, input bit [5:0] exp);
        @(negedge clk);
        lookup_addr = a;
        @(negedge clk);
        check(req, attr_o, exp);
        if (exp != exp_attr(a)) begin
            errors++;
            $display("FAIL %s model mismatch actual=%0h expected=%0h", req, exp_attr(a), exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit [7:0] rd;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        check("R1 attr in reset", attr_o, 6'h01);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 attr after reset", attr_o, 6'h01);
        // R1: no index held, stale read gives FF
        bus(8'h23, 1'b0, 8'h00, rd);
        check("R1 no index after reset", rd, 8'hFF);
        cfg_read_check("R1 reset window byte", 8'hC4);
        cfg_read_check("R1 reset control", 8'hE3);
        cfg_read_check("R1 reset global", 8'hE9);

        // R2/R4/R5 readback
        cfg_write(8'hC7, 8'hA5);
        cfg_read_check("R2 R4 window byte readback", 8'hC7);
        cfg_write(8'hDB, 8'h3C);
        cfg_read_check("R4 last window byte", 8'hDB);
        cfg_write(8'hE0, 8'h2A);
        cfg_read_check("R5 control readback", 8'hE0);
        cfg_write(8'hE9, 8'hFF);
        cfg_read_check("R5 global only bit5", 8'hE9);

        // R3 consumed index
        bus(8'h23, 1'b0, 8'h00, rd);
        check("R3 stale read", rd, 8'hFF);
        bus(8'h23, 1'b1, 8'h77, rd);
        cfg_read_check("R3 stale write ignored", 8'hE9);

        // R6 unimplemented
        foreach (m_rb[i]) model_write(8'(8'hC4 + i), m_rb[i]);
        cfg_write(8'hC3, 8'h55);
        cfg_read_check("R6 below range", 8'hC3);
        cfg_write(8'hE8, 8'h55);
        cfg_read_check("R6 gap index", 8'hE8);
        cfg_write(8'hFF, 8'h55);
        cfg_read_check("R6 top index", 8'hFF);
        cfg_read_check("R6 neighbour untouched", 8'hC4);

        // clear windows
        for (int i = 0; i < 8; i++) set_window(i, 32'h0, 4'd0, 8'h00);
        cfg_write(8'hE9, 8'h20);
        look("R11 no window", 32'h1234_5678, 6'h01);

        // R7 size boundaries, 1M window with misaligned start bits
        set_window(1, 32'h0010_5000, 4'd9, 8'h10);
        look("R7 low edge", 32'h0010_0000, 6'h11);
        look("R7 high edge", 32'h001F_FFFF, 6'h11);
        look("R7 above", 32'h0020_0000, 6'h01);
        look("R7 below", 32'h000F_FFFF, 6'h01);
        set_window(3, 32'hF000_0000, 4'd1, 8'h04);
        look("R7 4K inside", 32'hF000_0FFF, 6'h05);
        look("R7 4K outside", 32'hF000_1000, 6'h01);

        // R10 overlap: window 0 inside window 1
        set_window(0, 32'h0018_0000, 4'd7, 8'h3F);
        look("R10 lower wins", 32'h0018_1000, 6'h3E);
        look("R10 upper where alone", 32'h0010_0000, 6'h11);

        // R9 last window polarity, 4G size
        set_window(7, 32'h0, 4'd15, 8'h01);
        look("R9 last window cacheable", 32'h8000_0000, 6'h01);
        set_window(7, 32'h0, 4'd15, 8'h08);
        look("R9 last window uncached", 32'h8000_0000, 6'h08);
        set_window(2, 32'h4000_0000, 4'd14, 8'h01);
        look("R9 normal window disable", 32'h4100_0000, 6'h00);

        // R8 global off
        cfg_write(8'hE9, 8'h00);
        look("R8 global off", 32'h0018_1000, 6'h01);
        cfg_write(8'hE9, 8'h20);

        // R12 write and lookup in the same cycle
        look("R12 before", 32'h0010_0000, 6'h11);
        bus(8'h22, 1'b1, 8'hDD, rd);
        @(negedge clk);
        io_en = 1'b1; io_we = 1'b1; io_addr = 8'h23; io_wdata = 8'h01;
        lookup_addr = 32'h0010_0000;
        @(negedge clk);
        io_en = 1'b0; io_we = 1'b0;
        check("R12 old value same cycle", attr_o, 6'h11);
        model_write(8'hDD, 8'h01);
        @(negedge clk);
        check("R12 new value next cycle", attr_o, 6'h00);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            if (op < 3) begin
                int w = $urandom_range(0, 7);
                bit [31:0] st = $urandom;
                set_window(w, st, 4'($urandom_range(0, 15)), 8'($urandom));
            end else if (op == 3) begin
                cfg_write(8'hE9, ($urandom_range(0, 3) != 0) ? 8'h20 : 8'h00);
            end else if (op == 4) begin
                cfg_read_check("R4 R5 R6 random readback", 8'($urandom_range(8'hC0, 8'hEF)));
            end else begin
                int w = $urandom_range(0, 7);
                bit [31:0] a = {m_rb[3*w], m_rb[3*w+1], m_rb[3*w+2][7:4], 12'h000};
                a = a ^ ($urandom & ((32'd1 << $urandom_range(8, 28)) - 1));
                if (op == 9) a = $urandom;
                look("R7 R9 R10 random lookup", a, exp_attr(a));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule